// File: doc/BRIEF.md
# Eight-Word Row Write Sequencer

This block sits behind a serial programming front end. It gathers eight program words into a staging latch and then commits them as one aligned row into a nonvolatile memory model. The memory model has a user region and a small test region. The front end supplies the current address counter and a stream of load words. It also issues three single-cycle strobes: start a timed erase-and-write, start an untimed program-only write, and stop the untimed write. The entry that each load word lands in is chosen by the low three bits of the address counter.

A timed write runs by itself: it erases the row, programs it from the latch, and then drops the busy flag after a fixed number of cycles set by parameters. A program-only write skips the erase. Bits can then only be cleared, never set. The write holds busy until the stop strobe arrives, and it commits the row on that strobe. The word at 2007h, which sits inside the first test row, is only touched when the address counter points at it exactly.

Load words use a valid/ready handshake. A word is taken on a cycle where both `ld_valid` and `ld_ready` are high. The source must hold `ld_data` and `cur_addr` steady until that cycle. `ld_ready` stays low for the whole of a write and in the cycle a start command is taken. A read port gives a combinational view of the memory model.

Top module: `row_write_seq`

## Requirements
- R1: After reset `busy` is low, `ld_ready` is high, and every implemented word reads 3FFFh.
- R2: A load word is taken only when `ld_valid` and `ld_ready` are both high, and it is stored in latch entry `cur_addr[2:0]`. `ld_ready` is low while `busy` is high, so a word offered during a write has no effect on the latch.
- R3: A start strobe is taken only when all eight latch entries have been loaded since the last start that was taken. Otherwise the strobe is ignored and `busy` stays low.
- R4: A write covers the eight words from `{cur_addr[13:3],000}` to `{cur_addr[13:3],111}`, whatever the low three address bits are. Latch entry j goes to the word whose low bits equal j.
- R5: After a timed start, `busy` is high for exactly ERASE_CYC+PROG_CYC cycles, starting in the cycle after the strobe. Each written word then equals its latch entry, whatever its old value was.
- R6: After a program-only start, `busy` stays high until `cmd_end`. Each written word becomes the bitwise AND of its old value and its latch entry, so a bit that is already 0 stays 0.
- R7: `cmd_end` during a program-only write commits the row and drops `busy` in the next cycle. `cmd_end` while idle or during a timed write has no effect.
- R8: A row below USER_WORDS changes only user words. A row in 2000h to 2000h+TEST_WORDS-1 changes only test words. Any other address runs the timing but changes no stored word.
- R9: Word 2007h is written only when `cur_addr` is exactly 2007h at the start strobe. Other writes to its row leave it unchanged.
- R10: If both start strobes arrive in the same cycle, the timed write runs. Start strobes that arrive while `busy` is high are ignored.
- R11: `rd_data` shows the stored word at `rd_addr` in the same cycle, and shows 0 for addresses that are not implemented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_addr | input | 14 | Current address counter |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Load word can be taken |
| ld_data | input | 14 | Load word payload |
| cmd_erase_prog | input | 1 | Start timed erase-then-write strobe |
| cmd_prog_only | input | 1 | Start untimed program-only strobe |
| cmd_end | input | 1 | Stop program-only write strobe |
| busy | output | 1 | Write in progress |
| rd_addr | input | 14 | Read port address |
| rd_data | output | 14 | Read port data |

## Verification
The hardest case to reach is a load word offered during a write. That word is blocked, but its effect can only be seen later, through a start command that the block then refuses. To reach it, the bench offers a word for entry 0 while a write is running. After the write it refills only entries 1 to 7, checks that a start strobe leaves `busy` low, and then supplies entry 0 and checks that the next start strobe is taken. Random rows spread across the user, test and unimplemented ranges, with random modes and stop times, then drive the word-level reference model in the bench.

// File: rtl/rws_pkg.sv
package rws_pkg;
  localparam int WORD_W    = 14;
  localparam int ADDR_W    = 14;
  localparam int ROW_WORDS = 8;
  localparam int IDX_W     = $clog2(ROW_WORDS);
  localparam int LAT_W     = WORD_W * ROW_WORDS;

  localparam logic [WORD_W-1:0] ERASED_WORD = '1;
  localparam logic [ADDR_W-1:0] TEST_BASE   = 14'h2000;
  localparam logic [ADDR_W-1:0] CFG_ADDR    = 14'h2007;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ERASE,
    ST_PROG,
    ST_PONLY
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_ERASE,
    OP_WRITE,
    OP_MERGE
  } row_op_e;

  function automatic logic [WORD_W-1:0] next_word(row_op_e op,
                                                   logic [WORD_W-1:0] old_w,
                                                   logic [WORD_W-1:0] new_w);
    case (op)
      OP_ERASE: return ERASED_WORD;
      OP_WRITE: return new_w;
      OP_MERGE: return old_w & new_w;
      default:  return old_w;
    endcase
  endfunction
endpackage

// File: rtl/rws_latch.sv
module rws_latch
  import rws_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic             clr,
  output logic             full,
  output logic [LAT_W-1:0] data_flat
);
  logic [ROW_WORDS-1:0] filled;

  for (genvar gi = 0; gi < ROW_WORDS; gi++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_flat[gi*WORD_W +: WORD_W] <= ERASED_WORD;
        filled[gi] <= 1'b0;
      end else if (clr) begin
        filled[gi] <= 1'b0;
      end else if (hit) begin
        data_flat[gi*WORD_W +: WORD_W] <= wr_data;
        filled[gi] <= 1'b1;
      end
    end
  end

  assign full = &filled;
endmodule

// File: rtl/rws_ctrl.sv
module rws_ctrl
  import rws_pkg::*;
#(
  parameter int ERASE_CYC = 12,
  parameter int PROG_CYC  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_ep,
  input  logic              cmd_po,
  input  logic              cmd_end,
  input  logic              lat_full,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              busy,
  output logic              prog_only,
  output logic              start_acc,
  output row_op_e           op,
  output logic [ADDR_W-1:0] op_addr
);
  localparam int CNT_MAX = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seq_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic              start_ep, start_po, cnt_zero;

  assign start_ep  = (state == ST_IDLE) && cmd_ep && lat_full;
  assign start_po  = (state == ST_IDLE) && !cmd_ep && cmd_po && lat_full;
  assign start_acc = start_ep || start_po;
  assign cnt_zero  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      addr_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_ep) begin
            state  <= ST_ERASE;
            cnt    <= CNT_W'(ERASE_CYC - 1);
            addr_q <= cur_addr;
          end else if (start_po) begin
            state  <= ST_PONLY;
            addr_q <= cur_addr;
          end
        end
        ST_ERASE: begin
          if (cnt_zero) begin
            state <= ST_PROG;
            cnt   <= CNT_W'(PROG_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PROG: begin
          if (cnt_zero) state <= ST_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        ST_PONLY: begin
          if (cmd_end) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    op = OP_NONE;
    case (state)
      ST_ERASE: if (cnt_zero) op = OP_ERASE;
      ST_PROG:  if (cnt_zero) op = OP_WRITE;
      ST_PONLY: if (cmd_end)  op = OP_MERGE;
      default:  op = OP_NONE;
    endcase
  end

  assign busy      = (state != ST_IDLE);
  assign prog_only = (state == ST_PONLY);
  assign op_addr   = addr_q;
endmodule

// File: rtl/rws_array.sv
module rws_array
  import rws_pkg::*;
#(
  parameter int USER_WORDS = 64,
  parameter int TEST_WORDS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  row_op_e           op,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [LAT_W-1:0]  lat_flat,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] USER_END = ADDR_W'(USER_WORDS);
  localparam logic [ADDR_W-1:0] TEST_END = TEST_BASE + ADDR_W'(TEST_WORDS);

  logic [WORD_W-1:0] user_mem [USER_WORDS];
  logic [WORD_W-1:0] test_mem [TEST_WORDS];
  logic user_hit, test_hit, cfg_exact;

  assign user_hit  = (op != OP_NONE) && (op_addr < USER_END);
  assign test_hit  = (op != OP_NONE) && (op_addr >= TEST_BASE) && (op_addr < TEST_END);
  assign cfg_exact = (op_addr == CFG_ADDR);

  for (genvar gi = 0; gi < USER_WORDS; gi++) begin : g_user
    localparam logic [ADDR_W-1:0] WA = ADDR_W'(gi);
    logic sel;
    assign sel = user_hit && (op_addr[ADDR_W-1:IDX_W] == WA[ADDR_W-1:IDX_W]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   user_mem[gi] <= ERASED_WORD;
      else if (sel) user_mem[gi] <= next_word(op, user_mem[gi],
                                     lat_flat[(gi % ROW_WORDS)*WORD_W +: WORD_W]);
    end
  end

  for (genvar gi = 0; gi < TEST_WORDS; gi++) begin : g_test
    localparam logic [ADDR_W-1:0] WA = TEST_BASE + ADDR_W'(gi);
    localparam bit IS_CFG = (WA == CFG_ADDR);
    logic sel;
    assign sel = test_hit && (op_addr[ADDR_W-1:IDX_W] == WA[ADDR_W-1:IDX_W])
                 && (!IS_CFG || cfg_exact);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   test_mem[gi] <= ERASED_WORD;
      else if (sel) test_mem[gi] <= next_word(op, test_mem[gi],
                                     lat_flat[(gi % ROW_WORDS)*WORD_W +: WORD_W]);
    end
  end

  logic [ADDR_W-1:0] test_off;
  assign test_off = rd_addr - TEST_BASE;

  always_comb begin
    rd_data = '0;
    if (rd_addr < USER_END)
      rd_data = user_mem[rd_addr[$clog2(USER_WORDS)-1:0]];
    else if ((rd_addr >= TEST_BASE) && (rd_addr < TEST_END))
      rd_data = test_mem[test_off[$clog2(TEST_WORDS)-1:0]];
  end
endmodule

// File: rtl/row_write_seq.sv
module row_write_seq
  import rws_pkg::*;
#(
  parameter int USER_WORDS = 64,
  parameter int TEST_WORDS = 32,
  parameter int ERASE_CYC  = 12,
  parameter int PROG_CYC   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              cmd_erase_prog,
  input  logic              cmd_prog_only,
  input  logic              cmd_end,
  output logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic              lat_full, start_acc, prog_only, ld_fire;
  logic [LAT_W-1:0]  lat_flat;
  logic [ADDR_W-1:0] op_addr;
  row_op_e           op;

  assign ld_ready = !busy && !start_acc;
  assign ld_fire  = ld_valid && ld_ready;

  rws_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ld_fire),
    .wr_idx    (cur_addr[IDX_W-1:0]),
    .wr_data   (ld_data),
    .clr       (start_acc),
    .full      (lat_full),
    .data_flat (lat_flat)
  );

  rws_ctrl #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ep    (cmd_erase_prog),
    .cmd_po    (cmd_prog_only),
    .cmd_end   (cmd_end),
    .lat_full  (lat_full),
    .cur_addr  (cur_addr),
    .busy      (busy),
    .prog_only (prog_only),
    .start_acc (start_acc),
    .op        (op),
    .op_addr   (op_addr)
  );

  rws_array #(.USER_WORDS(USER_WORDS), .TEST_WORDS(TEST_WORDS)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .op_addr  (op_addr),
    .lat_flat (lat_flat),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/row_write_seq_chk.sv
module row_write_seq_chk
  import rws_pkg::*;
#(
  parameter int ERASE_CYC = 12,
  parameter int PROG_CYC  = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             prog_only,
  input logic             cmd_end,
  input logic             lat_full,
  input logic [LAT_W-1:0] lat_flat
);
  localparam int TOTAL = ERASE_CYC + PROG_CYC;

  int   run_cnt;
  logic was_ponly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt   <= 0;
      was_ponly <= 1'b0;
    end else begin
      run_cnt   <= busy ? run_cnt + 1 : 0;
      was_ponly <= busy ? (was_ponly | prog_only) : 1'b0;
    end
  end

  AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(lat_flat)); // R2
  AST_START_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(lat_full)); // R3
  AST_TIMED_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !was_ponly) |-> (run_cnt == TOTAL)); // R5
  AST_PONLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && prog_only && !cmd_end) |=> busy); // R6
  AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && prog_only && cmd_end) |=> !busy); // R7
endmodule

bind row_write_seq row_write_seq_chk #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .prog_only (prog_only),
  .cmd_end   (cmd_end),
  .lat_full  (lat_full),
  .lat_flat  (lat_flat)
);

// File: tb/row_write_seq_bench.sv
`timescale 1ns/1ps
module row_write_seq_bench;
  localparam int USER_W = 64;
  localparam int TEST_W = 32;
  localparam int E_CYC  = 12;
  localparam int P_CYC  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [13:0] cur_addr = '0, ld_data = '0, rd_addr = '0;
  logic ld_valid = 1'b0, cmd_erase_prog = 1'b0, cmd_prog_only = 1'b0, cmd_end = 1'b0;
  logic ld_ready, busy;
  logic [13:0] rd_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [13:0] ref_user [USER_W];
  logic [13:0] ref_test [TEST_W];
  logic [13:0] ref_lat [8];

  always #2 clk = ~clk;

  row_write_seq #(.USER_WORDS(USER_W), .TEST_WORDS(TEST_W),
                  .ERASE_CYC(E_CYC), .PROG_CYC(P_CYC)) u_row_write_seq (
    .clk(clk), .rst_n(rst_n), .cur_addr(cur_addr), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_data(ld_data), .cmd_erase_prog(cmd_erase_prog),
    .cmd_prog_only(cmd_prog_only), .cmd_end(cmd_end), .busy(busy),
    .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [13:0] ref_read(int a);
    if (a < USER_W) return ref_user[a];
    if (a >= 'h2000 && a < 'h2000 + TEST_W) return ref_test[a - 'h2000];
    return 14'h0;
  endfunction

  function automatic void ref_apply(logic [13:0] a, bit po);
    for (int j = 0; j < 8; j++) begin
      int wa;
      wa = {a[13:3], 3'(j)};
      if (wa < USER_W)
        ref_user[wa] = po ? (ref_user[wa] & ref_lat[j]) : ref_lat[j];
      else if (wa >= 'h2000 && wa < 'h2000 + TEST_W && !(wa == 'h2007 && a != 14'h2007))
        ref_test[wa - 'h2000] = po ? (ref_test[wa - 'h2000] & ref_lat[j]) : ref_lat[j];
    end
  endfunction

  task automatic compare_all(string req);
    int bad = 0;
    for (int a = 0; a < USER_W + TEST_W; a++) begin
      int ad;
      ad = (a < USER_W) ? a : ('h2000 + a - USER_W);
      rd_addr = 14'(ad);
      #1;
      if (rd_data !== ref_read(ad)) begin
        bad++;
        $display("FAIL %s word %0h: actual %0h expected %0h", req, ad, rd_data, ref_read(ad));
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic load(logic [13:0] a, logic [13:0] d, output bit took);
    cur_addr = a; ld_data = d; ld_valid = 1'b1;
    #1;
    took = ld_ready;
    if (took) ref_lat[a[2:0]] = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic load_row(logic [13:0] a);
    bit t;
    for (int j = 0; j < 8; j++) load({a[13:3], 3'(j)}, 14'($urandom), t);
  endtask

  task automatic run_begin(logic [13:0] a, bit ep, bit po, int end_after, output int n);
    cur_addr = a; cmd_erase_prog = ep; cmd_prog_only = po;
    @(negedge clk);
    cmd_erase_prog = 1'b0; cmd_prog_only = 1'b0;
    n = 0;
    while (busy && n < 5000) begin
      n++;
      if (n == end_after) cmd_end = 1'b1;
      @(negedge clk);
      cmd_end = 1'b0;
    end
  endtask

  initial begin
    int n;
    bit t;
    void'($urandom(32'd7319));
    for (int i = 0; i < USER_W; i++) ref_user[i] = 14'h3FFF;
    for (int i = 0; i < TEST_W; i++) ref_test[i] = 14'h3FFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(ld_ready == 1'b1, "R1", "ready after reset", ld_ready, 1);
    compare_all("R1");
    rd_addr = 14'h1000; #1;
    chk(rd_data == 14'h0, "R11", "unimplemented read", rd_data, 0);

    // R4 R5: timed write at misaligned address 3, with a stray end (R7)
    load_row(14'h0000);
    run_begin(14'h0003, 1'b1, 1'b0, 5, n);
    chk(n == E_CYC + P_CYC, "R5", "timed busy length", n, E_CYC + P_CYC);
    ref_apply(14'h0003, 1'b0);
    compare_all("R4");

    // R6 R7: program-only merges and waits for end
    load_row(14'h0000);
    run_begin(14'h0005, 1'b0, 1'b1, 60, n);
    chk(n == 60, "R6", "program-only held until end", n, 60);
    ref_apply(14'h0005, 1'b1);
    compare_all("R6");
    // R7: end while idle has no effect
    cmd_end = 1'b1; @(negedge clk); cmd_end = 1'b0;
    chk(busy == 1'b0, "R7", "end while idle", busy, 0);
    compare_all("R7");

    // R2 R3: load offered during a write is not taken
    load_row(14'h0008);
    cur_addr = 14'h0008; cmd_erase_prog = 1'b1; @(negedge clk); cmd_erase_prog = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    load(14'h0010, 14'h1234, t);
    chk(t == 1'b0, "R2", "ready during write", t, 0);
    ref_apply(14'h0008, 1'b0);
    // R10: a start while busy is ignored (latch also empty)
    cur_addr = 14'h0030; cmd_prog_only = 1'b1; @(negedge clk); cmd_prog_only = 1'b0;
    while (busy) @(negedge clk);
    for (int j = 1; j < 8; j++) load(14'h0010 + 14'(j), 14'($urandom), t);
    run_begin(14'h0010, 1'b1, 1'b0, -1, n);
    chk(n == 0, "R3", "start with entry 0 missing", n, 0);
    compare_all("R2");
    load(14'h0010, 14'h0abc, t);
    run_begin(14'h0010, 1'b1, 1'b1, -1, n);
    chk(n == E_CYC + P_CYC, "R10", "both strobes give timed write", n, E_CYC + P_CYC);
    ref_apply(14'h0010, 1'b0);
    compare_all("R10");

    // R8 R9: test row, config word protected unless exact
    load_row(14'h2000);
    run_begin(14'h2003, 1'b1, 1'b0, -1, n);
    ref_apply(14'h2003, 1'b0);
    rd_addr = 14'h2007; #1;
    chk(rd_data == 14'h3FFF, "R9", "config word untouched", rd_data, 14'h3FFF);
    compare_all("R8");
    load_row(14'h2000);
    run_begin(14'h2007, 1'b1, 1'b0, -1, n);
    ref_apply(14'h2007, 1'b0);
    rd_addr = 14'h2007; #1;
    chk(rd_data == ref_lat[7], "R9", "config word exact", rd_data, ref_lat[7]);
    compare_all("R9");
    load_row(14'h1000);
    run_begin(14'h1004, 1'b1, 1'b0, -1, n);
    chk(n == E_CYC + P_CYC, "R8", "unimplemented row timing", n, E_CYC + P_CYC);
    compare_all("R8");

    // random mix across regions and modes
    for (int it = 0; it < 40; it++) begin
      logic [13:0] a;
      bit po;
      int k, sel;
      sel = $urandom_range(0, 9);
      if (sel < 5)      a = 14'($urandom_range(0, USER_W - 1));
      else if (sel < 9) a = 14'h2000 + 14'($urandom_range(0, TEST_W - 1));
      else              a = 14'h0800 + 14'($urandom_range(0, 255));
      po = $urandom_range(0, 1);
      k = $urandom_range(1, 40);
      load_row(a);
      run_begin(a, !po, po, po ? k : -1, n);
      chk(n == (po ? k : E_CYC + P_CYC), po ? "R6" : "R5", "random busy length",
          n, po ? k : E_CYC + P_CYC);
      ref_apply(a, po);
      compare_all(po ? "R6" : "R5");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule